// File: doc/BRIEF.md
# Parallel-Port IDE Bridge Engine

This block is the device-side engine of a bridge that gives a host on a legacy parallel port access to an IDE register file and data port. The host controls it with four control lines plus a direction line. It passes bytes over an 8-bit data bus and gets nibbles back on a 4-bit status output. The block synchronises those asynchronous lines. It then watches the control lines for a fixed pulse pattern and latches the data byte as a command. After that, each control step is turned into single-cycle read or write strobes on a simple synchronous register interface toward the IDE side.

A command is a byte. It selects one of two register banks (the IDE register file or the command set) and a 3-bit register index. It also selects the transfer style: register access, or byte-wide block read. In a register access, the host reads a byte back one nibble at a time through the status lines, and writes bytes with a two-step strobe; repeating the strobe streams a block of writes. In a byte-wide block read, the host raises the direction line and toggles one control line. Each toggle fetches the next IDE byte, and the block drives that byte on the data bus. Any command byte that is not a valid access, such as 0x20, disconnects the engine until a new command arrives.

Top module: `ppide_bridge`

## Requirements
- R1: A command is taken only after the direction line is low and the control value steps through 0xC, 0xE, 0xC, 0x4. The command byte is the data value present on the first 0xC step. After the final 0x4 step, the bank and index appear on `ide_sel_o`/`ide_idx_o`.
- R2: A control step that breaks the command pattern before it completes returns the detector to idle. The previously active command stays in force.
- R3: Command byte decoding:
  - Bits 7:6 = 00, bit 5 = 0 and bits 4:3 = 01 give a register access to bank 0 (register file).
  - Bits 4:3 = 10 with the same upper bits give bank 1 (command set).
  - Bits 2:0 give the register index.
- R4: Under a register-access command, a step to control 0x6 (direction low) issues exactly one IDE read. Afterwards `pp_stat_o` shows bits 3:0 of the byte read. A following step to 0x4 makes `pp_stat_o` show bits 7:4.
- R5: Under a register-access command, a step from control 0x5 to 0x7 issues exactly one IDE write of the synchronised data byte. Steps 0x7 to 0x5 and 0x5 to 0x4 write nothing. Repeated 0x7/0x5 pulses write one byte each.
- R6: A command with bits 7:6 = 11, bit 5 = 0 and bits 4:3 of 01 or 10 selects a byte-wide block read. Each step to direction-high control 0x6 or 0x4 issues one IDE read, and the byte read is then presented on `pp_data_o`.
- R7: `pp_data_oe` is high only while the direction line is high and a block-read command is active. It is low under register-access commands.
- R8: In a block read, a direction-high step to 0xC ends the burst. The following direction-high 0x4 step issues no read, and `pp_data_oe` falls once the direction line returns low.
- R9: Any command byte not matching R3 or R6, for example 0x20, leaves no active command. After it, write pulses, read steps and the direction line have no effect until a new command is latched.
- R10: Holding a control value for any number of cycles counts as a single step. A held 0x7 produces one write only.
- R11: After reset no strobe is active, `pp_data_oe` is low, `pp_stat_o` is 0 and no command is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pp_data_i | input | 8 | Host data lines as driven by the host |
| pp_data_o | output | 8 | Byte the engine drives onto the host data lines |
| pp_data_oe | output | 1 | Enable for `pp_data_o` on the shared data lines |
| pp_ctrl_i | input | 4 | Host control lines (asynchronous) |
| pp_dir_i | input | 1 | Host direction line; high means the engine drives data |
| pp_stat_o | output | 4 | Nibble returned on host status lines 7:4 |
| ide_sel_o | output | 1 | Bank select: 0 register file, 1 command set |
| ide_idx_o | output | 3 | Register index inside the selected bank |
| ide_rd_o | output | 1 | One-cycle read strobe; data is expected on `ide_rdata_i` the next cycle |
| ide_wr_o | output | 1 | One-cycle write strobe |
| ide_wdata_o | output | 8 | Write data, valid with `ide_wr_o` |
| ide_rdata_i | input | 8 | Read data, valid the cycle after `ide_rd_o` |

## Verification
The assertions hold the properties that are true on every cycle:
- Strobes last a single cycle.
- Writes appear only under a register-access command, and reads never appear without an active command.
- The data bus is enabled only under a block-read command.
- The latched command never changes in a cycle without a control step.

The bench scenarios are needed for behaviour that depends on ordering:
- pattern completion versus breakage;
- which bank and index a byte reaches;
- nibble order on the status lines;
- the byte sequence of a block read and its closing step;
- the quiet state after a disconnect.

// File: rtl/ppide_pkg.sv
package ppide_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_REG   = 2'd1,
        CMD_BLKRD = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic       sel;
        logic [2:0] idx;
    } cmd_t;

    localparam int CTRL_W = 5;  // {direction, control[3:0]}

    localparam logic [CTRL_W-1:0] CV_C     = 5'h0C;
    localparam logic [CTRL_W-1:0] CV_E     = 5'h0E;
    localparam logic [CTRL_W-1:0] CV_IDLE  = 5'h04;
    localparam logic [CTRL_W-1:0] CV_ARM   = 5'h05;
    localparam logic [CTRL_W-1:0] CV_NIBLO = 5'h06;
    localparam logic [CTRL_W-1:0] CV_STRB  = 5'h07;
    localparam logic [CTRL_W-1:0] CV_BRD_A = 5'h16;
    localparam logic [CTRL_W-1:0] CV_BRD_B = 5'h14;
    localparam logic [CTRL_W-1:0] CV_BEND  = 5'h1C;

    localparam cmd_t CMD_RESET = '{kind: CMD_NONE, sel: 1'b0, idx: 3'd0};

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.kind = CMD_NONE;
        c.sel  = b[4];
        c.idx  = b[2:0];
        if (!b[5] && (b[4] ^ b[3])) begin
            if (b[7:6] == 2'b00) begin
                c.kind = CMD_REG;
            end else if (b[7:6] == 2'b11) begin
                c.kind = CMD_BLKRD;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/ppide_sync.sv
module ppide_sync #(
    parameter int W      = 13,
    parameter int CW     = 5,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  async_i,
    output logic [W-1:0]  val_o,
    output logic [CW-1:0] prev_o,
    output logic          step_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [CW-1:0]            prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        st_d.prev  = st_q.chain[STAGES-1][CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o  = st_q.chain[STAGES-1];
    assign prev_o = st_q.prev;
    assign step_o = (st_q.chain[STAGES-1][CW-1:0] != st_q.prev);

endmodule

// File: rtl/ppide_cmd_seq.sv
module ppide_cmd_seq
    import ppide_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [CTRL_W-1:0] val_i,
    input  logic [DATA_W-1:0] data_i,
    output cmd_t              cmd_o
);

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_C1   = 2'd1,
        SQ_E    = 2'd2,
        SQ_C2   = 2'd3
    } seq_e;

    typedef struct packed {
        seq_e              st;
        logic [DATA_W-1:0] pend;
        cmd_t              cmd;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            unique case (st_q.st)
                SQ_IDLE: begin
                    if (val_i == CV_C) begin
                        st_d.st   = SQ_C1;
                        st_d.pend = data_i;
                    end
                end
                SQ_C1: begin
                    st_d.st = (val_i == CV_E) ? SQ_E : SQ_IDLE;
                end
                SQ_E: begin
                    st_d.st = (val_i == CV_C) ? SQ_C2 : SQ_IDLE;
                end
                SQ_C2: begin
                    st_d.st = SQ_IDLE;
                    if (val_i == CV_IDLE) begin
                        st_d.cmd = decode_cmd(st_q.pend[7:0]);
                    end
                end
                default: st_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st   <= SQ_IDLE;
            st_q.pend <= '0;
            st_q.cmd  <= CMD_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o = st_q.cmd;

    AST_SEQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == SQ_C2) |-> $past(st_q.st == SQ_E || st_q.st == SQ_C2)); // R1

endmodule

// File: rtl/ppide_xfer.sv
module ppide_xfer
    import ppide_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [CTRL_W-1:0] val_i,
    input  logic [CTRL_W-1:0] prev_i,
    input  logic [DATA_W-1:0] data_i,
    input  cmd_t              cmd_i,
    input  logic [DATA_W-1:0] ide_rdata_i,
    output logic              ide_rd_o,
    output logic              ide_wr_o,
    output logic [DATA_W-1:0] ide_wdata_o,
    output logic [DATA_W-1:0] pp_data_o,
    output logic              pp_data_oe,
    output logic [NIB_W-1:0]  pp_stat_o
);

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              rd_pend;
        logic [DATA_W-1:0] rbyte;
        logic              nib_hi;
        logic              closing;
        logic              oe;
    } xf_st_t;

    xf_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.rd      = 1'b0;
        st_d.wr      = 1'b0;
        st_d.rd_pend = st_q.rd;
        st_d.oe      = val_i[CTRL_W-1] && (cmd_i.kind == CMD_BLKRD);
        if (st_q.rd_pend) begin
            st_d.rbyte = ide_rdata_i;
        end
        if (step_i) begin
            unique case (cmd_i.kind)
                CMD_REG: begin
                    if (val_i == CV_NIBLO) begin
                        st_d.rd     = 1'b1;
                        st_d.nib_hi = 1'b0;
                    end else if (val_i == CV_IDLE) begin
                        st_d.nib_hi = 1'b1;
                    end
                    if (val_i == CV_STRB && prev_i == CV_ARM) begin
                        st_d.wr    = 1'b1;
                        st_d.wdata = data_i;
                    end
                end
                CMD_BLKRD: begin
                    if ((val_i == CV_BRD_A || val_i == CV_BRD_B) && !st_q.closing) begin
                        st_d.rd = 1'b1;
                    end
                    if (val_i == CV_BEND) begin
                        st_d.closing = 1'b1;
                    end
                    if (!val_i[CTRL_W-1]) begin
                        st_d.closing = 1'b0;
                    end
                end
                default: begin
                    st_d.closing = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ide_rd_o    = st_q.rd;
    assign ide_wr_o    = st_q.wr;
    assign ide_wdata_o = st_q.wdata;
    assign pp_data_o   = st_q.rbyte;
    assign pp_data_oe  = st_q.oe;
    assign pp_stat_o   = st_q.nib_hi ? st_q.rbyte[DATA_W-1:NIB_W] : st_q.rbyte[NIB_W-1:0];

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ide_rd_o |=> !ide_rd_o); // R6

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ide_wr_o |=> !ide_wr_o); // R10

    AST_NO_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
        !(ide_rd_o && ide_wr_o)); // R4

endmodule

// File: rtl/ppide_bridge.sv
module ppide_bridge
    import ppide_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int NIB_W       = DATA_W / 2,
    parameter int IDX_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pp_data_i,
    output logic [DATA_W-1:0] pp_data_o,
    output logic              pp_data_oe,
    input  logic [3:0]        pp_ctrl_i,
    input  logic              pp_dir_i,
    output logic [NIB_W-1:0]  pp_stat_o,
    output logic              ide_sel_o,
    output logic [IDX_W-1:0]  ide_idx_o,
    output logic              ide_rd_o,
    output logic              ide_wr_o,
    output logic [DATA_W-1:0] ide_wdata_o,
    input  logic [DATA_W-1:0] ide_rdata_i
);

    localparam int SYNC_W = DATA_W + CTRL_W;

    logic [SYNC_W-1:0] sync_val;
    logic [CTRL_W-1:0] ctl_val;
    logic [CTRL_W-1:0] ctl_prev;
    logic [DATA_W-1:0] data_val;
    logic              ctl_step;
    cmd_t              cmd;

    ppide_sync #(
        .W      (SYNC_W),
        .CW     (CTRL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pp_data_i, pp_dir_i, pp_ctrl_i}),
        .val_o   (sync_val),
        .prev_o  (ctl_prev),
        .step_o  (ctl_step)
    );

    assign ctl_val  = sync_val[CTRL_W-1:0];
    assign data_val = sync_val[SYNC_W-1:CTRL_W];

    ppide_cmd_seq #(
        .DATA_W (DATA_W)
    ) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (ctl_step),
        .val_i  (ctl_val),
        .data_i (data_val),
        .cmd_o  (cmd)
    );

    ppide_xfer #(
        .DATA_W (DATA_W),
        .NIB_W  (NIB_W)
    ) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (ctl_step),
        .val_i       (ctl_val),
        .prev_i      (ctl_prev),
        .data_i      (data_val),
        .cmd_i       (cmd),
        .ide_rdata_i (ide_rdata_i),
        .ide_rd_o    (ide_rd_o),
        .ide_wr_o    (ide_wr_o),
        .ide_wdata_o (ide_wdata_o),
        .pp_data_o   (pp_data_o),
        .pp_data_oe  (pp_data_oe),
        .pp_stat_o   (pp_stat_o)
    );

    assign ide_sel_o = cmd.sel;
    assign ide_idx_o = cmd.idx;

    AST_CMD_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_step |=> $stable(cmd)); // R2

    AST_WR_NEEDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        ide_wr_o |-> (cmd.kind == CMD_REG)); // R5

    AST_RD_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ide_rd_o |-> (cmd.kind != CMD_NONE)); // R9

    AST_OE_BLKRD: assert property (@(posedge clk) disable iff (!rst_n)
        pp_data_oe |-> (cmd.kind == CMD_BLKRD)); // R7

endmodule

// File: tb/ppide_bridge_tb.sv
module ppide_bridge_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pp_data_i = 8'h00;
    logic [7:0] pp_data_o;
    logic       pp_data_oe;
    logic [3:0] pp_ctrl_i = 4'h0;
    logic       pp_dir_i = 1'b0;
    logic [3:0] pp_stat_o;
    logic       ide_sel_o;
    logic [2:0] ide_idx_o;
    logic       ide_rd_o;
    logic       ide_wr_o;
    logic [7:0] ide_wdata_o;
    logic [7:0] ide_rdata_i = 8'h00;

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [7:0] stream_cnt = 8'h00;
    logic [7:0] regs [16];
    logic [11:0] exp_wr [$];

    always #10 clk = ~clk;

    ppide_bridge u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pp_data_i   (pp_data_i),
        .pp_data_o   (pp_data_o),
        .pp_data_oe  (pp_data_oe),
        .pp_ctrl_i   (pp_ctrl_i),
        .pp_dir_i    (pp_dir_i),
        .pp_stat_o   (pp_stat_o),
        .ide_sel_o   (ide_sel_o),
        .ide_idx_o   (ide_idx_o),
        .ide_rd_o    (ide_rd_o),
        .ide_wr_o    (ide_wr_o),
        .ide_wdata_o (ide_wdata_o),
        .ide_rdata_i (ide_rdata_i)
    );

    // IDE side model: bank 0 index 0 streams A0, A1, ... on reads
    always @(posedge clk) begin
        if (rst_n) begin
            if (ide_wr_o) begin
                regs[{ide_sel_o, ide_idx_o}] <= ide_wdata_o;
                wr_cnt <= wr_cnt + 1;
            end
            if (ide_rd_o) begin
                rd_cnt <= rd_cnt + 1;
                if (!ide_sel_o && ide_idx_o == 3'd0) begin
                    ide_rdata_i <= 8'hA0 + stream_cnt;
                    stream_cnt  <= stream_cnt + 8'd1;
                end else begin
                    ide_rdata_i <= regs[{ide_sel_o, ide_idx_o}];
                end
            end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor for writes
    always @(negedge clk) begin
        if (rst_n && ide_wr_o) begin
            checks++;
            if (exp_wr.size() == 0) begin
                failures++;
                $display("FAIL R5 unexpected write: actual=%0h expected=none",
                         {ide_sel_o, ide_idx_o, ide_wdata_o});
            end else begin
                logic [11:0] e;
                e = exp_wr.pop_front();
                if ({ide_sel_o, ide_idx_o, ide_wdata_o} !== e) begin
                    failures++;
                    $display("FAIL R5 write target/data: actual=%0h expected=%0h",
                             {ide_sel_o, ide_idx_o, ide_wdata_o}, e);
                end
            end
        end
    end

    task automatic set_ctrl(input logic [4:0] v);
        @(negedge clk);
        pp_dir_i  = v[4];
        pp_ctrl_i = v[3:0];
        repeat (6) @(negedge clk);
    endtask

    task automatic cmd_phase(input logic [7:0] b);
        @(negedge clk);
        pp_data_i = b;
        set_ctrl(5'h0C);
        set_ctrl(5'h0E);
        set_ctrl(5'h0E);
        set_ctrl(5'h0C);
        set_ctrl(5'h04);
        set_ctrl(5'h04);
        set_ctrl(5'h04);
    endtask

    task automatic strobe_byte(input logic [7:0] v);
        @(negedge clk);
        pp_data_i = v;
        set_ctrl(5'h07);
        set_ctrl(5'h05);
    endtask

    task automatic reg_read(input logic [7:0] c, input logic [7:0] exp, input string req);
        logic [3:0] lo;
        logic [3:0] hi;
        cmd_phase(c);
        set_ctrl(5'h06);
        lo = pp_stat_o;
        set_ctrl(5'h04);
        hi = pp_stat_o;
        check(req, "nibble read byte", {24'h0, hi, lo}, {24'h0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int wr0;
        int rd0;
        for (int i = 0; i < 16; i++) regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "oe after reset", {31'h0, pp_data_oe}, 32'h0);
        check("R11", "stat after reset", {28'h0, pp_stat_o}, 32'h0);
        check("R11", "strobes after reset", {30'h0, ide_rd_o, ide_wr_o}, 32'h0);
        rst_n = 1'b1;
        set_ctrl(5'h04);
        check("R11", "no strobes at idle", rd_cnt + wr_cnt, 32'h0);

        // R1 R3 R5: register write to bank 0 index 2
        cmd_phase(8'h0A);
        check("R1", "bank/index after command", {28'h0, ide_sel_o, ide_idx_o}, 32'h2);
        exp_wr.push_back({1'b0, 3'd2, 8'h5A});
        wr0 = wr_cnt;
        set_ctrl(5'h05);
        strobe_byte(8'h5A);
        set_ctrl(5'h04);
        check("R5", "one write per pulse", wr_cnt - wr0, 32'd1);

        // R4: nibble read back
        reg_read(8'h0A, 8'h5A, "R4");

        // R3: command set bank
        cmd_phase(8'h13);
        check("R3", "command-set bank select", {28'h0, ide_sel_o, ide_idx_o}, 32'hB);
        exp_wr.push_back({1'b1, 3'd3, 8'hC3});
        set_ctrl(5'h05);
        strobe_byte(8'hC3);
        set_ctrl(5'h04);
        reg_read(8'h13, 8'hC3, "R3");
        reg_read(8'h0B, 8'h00, "R3");

        // R7: direction high under a register command
        set_ctrl(5'h14);
        check("R7", "no drive under register command", {31'h0, pp_data_oe}, 32'h0);
        set_ctrl(5'h04);

        // R5 R10: block write with a held strobe
        cmd_phase(8'h08);
        exp_wr.push_back({1'b0, 3'd0, 8'h11});
        exp_wr.push_back({1'b0, 3'd0, 8'h22});
        exp_wr.push_back({1'b0, 3'd0, 8'h33});
        wr0 = wr_cnt;
        set_ctrl(5'h05);
        strobe_byte(8'h11);
        @(negedge clk);
        pp_data_i = 8'h22;
        set_ctrl(5'h07);
        repeat (30) @(negedge clk);
        check("R10", "held strobe writes once", wr_cnt - wr0, 32'd2);
        set_ctrl(5'h05);
        strobe_byte(8'h33);
        set_ctrl(5'h04);
        check("R5", "block write count", wr_cnt - wr0, 32'd3);

        // R2: broken pattern keeps the old command
        cmd_phase(8'h0A);
        @(negedge clk);
        pp_data_i = 8'h13;
        set_ctrl(5'h0C);
        set_ctrl(5'h0E);
        set_ctrl(5'h05);
        set_ctrl(5'h04);
        check("R2", "command kept after break", {28'h0, ide_sel_o, ide_idx_o}, 32'h2);
        exp_wr.push_back({1'b0, 3'd2, 8'h77});
        set_ctrl(5'h05);
        strobe_byte(8'h77);
        set_ctrl(5'h04);

        // R6 R7 R8: byte-wide block read
        cmd_phase(8'hC8);
        @(negedge clk);
        pp_data_i = 8'hFF;
        rd0 = rd_cnt;
        set_ctrl(5'h16);
        check("R7", "drive enabled in block read", {31'h0, pp_data_oe}, 32'h1);
        check("R6", "block byte 0", {24'h0, pp_data_o}, 32'hA0);
        set_ctrl(5'h14);
        check("R6", "block byte 1", {24'h0, pp_data_o}, 32'hA1);
        set_ctrl(5'h16);
        check("R6", "block byte 2", {24'h0, pp_data_o}, 32'hA2);
        set_ctrl(5'h14);
        check("R6", "block byte 3", {24'h0, pp_data_o}, 32'hA3);
        check("R6", "reads in burst", rd_cnt - rd0, 32'd4);
        set_ctrl(5'h1C);
        set_ctrl(5'h14);
        check("R8", "no read after end step", rd_cnt - rd0, 32'd4);
        check("R8", "byte held after end", {24'h0, pp_data_o}, 32'hA3);
        check("R8", "still driving before dir low", {31'h0, pp_data_oe}, 32'h1);
        set_ctrl(5'h04);
        check("R8", "drive released", {31'h0, pp_data_oe}, 32'h0);

        // R9: disconnect
        cmd_phase(8'h20);
        wr0 = wr_cnt;
        rd0 = rd_cnt;
        set_ctrl(5'h05);
        strobe_byte(8'h99);
        set_ctrl(5'h04);
        set_ctrl(5'h06);
        set_ctrl(5'h04);
        set_ctrl(5'h16);
        check("R9", "no drive after disconnect", {31'h0, pp_data_oe}, 32'h0);
        set_ctrl(5'h14);
        set_ctrl(5'h04);
        check("R9", "no strobes after disconnect", (wr_cnt - wr0) + (rd_cnt - rd0), 32'd0);
        reg_read(8'h0A, 8'h77, "R9");
        check("R5", "all expected writes seen", exp_wr.size(), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule